// File: doc/BRIEF.md
# Clock Synthesis Setting Register Port

This block is the slave side of a small synchronous register port. A clock-synthesis unit uses it to receive its multiply and divide settings. A host starts an access by raising `en` for one cycle and presents `addr`, `we` and `wdata` in that cycle. The block captures the address and performs a write if one is requested. It answers every access with a single-cycle `rdy` pulse at a fixed distance from the enable cycle. The read-data bus is combinational from the captured address, so it always shows the current contents of the location that was accessed last.

There are two setting registers, and each is five bits wide. The multiply register holds the multiply factor minus one. The divide register holds the divide factor minus one. Both values are driven out continuously to the synthesis unit. Four live status inputs from the synthesis unit are visible at address zero. After reset the captured address is zero, so the read bus shows those flags until the first access elsewhere. After that, an explicit access to address zero is needed to bring them back.

The port has no data stream, so it has no valid/ready handshake. Flow control is a single rule: an access occupies the port until its `rdy` pulse. Any `en` that arrives while the port is busy is dropped, and the host must wait for `rdy` before it starts the next access.

Top module: `clkmgr_cfg_port`

## Requirements
- R1: `addr` is captured on the rising clock edge of every cycle in which an access is accepted (`en` high while the port is idle). The captured address changes at no other time except reset.
- R2: `rdata` follows the captured address combinationally. Address 0 gives the status word, 50h gives the multiply code in bits [4:0], and 52h gives the divide code in bits [4:0]. In each case the other bits are zero.
- R3: While `rst` (active high, synchronous) is asserted, the captured address becomes 0, the multiply code becomes 1, the divide code becomes 0 and `rdy` is low. After reset, `rdata` shows the status word.
- R4: The status word has bit0 = phase-shift overflow, bit1 = input clock stopped, bit2 = synthesized clock stopped and bit3 = feedback clock stopped. Bits [15:4] are zero. Once an access has moved the captured address away from 0, the status word is shown again only after an access to address 0.
- R5: A write to address 50h with a nonzero `wdata[4:0]` stores that value as the multiply code (code k means multiply by k+1, so 1 is ×2 and 31 is ×32). `wdata[15:5]` is ignored.
- R6: A write to 50h with `wdata[4:0]` = 0 leaves the multiply code unchanged. The stored multiply code is never 0.
- R7: A write to address 52h stores `wdata[4:0]` as the divide code (code k means divide by k+1).
- R8: For each accepted access, read or write, `rdy` is high for exactly one cycle, two cycles after the enable cycle.
- R9: Writes to any address other than 50h and 52h are acknowledged but change no register. Reads of such addresses return zero.
- R10: An `en` that arrives while an earlier access is still waiting for its `rdy` is ignored. It does not capture an address, perform a write or produce a `rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Access request, one cycle |
| we | input | 1 | Write when high, read when low |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Contents of the last captured address |
| rdy | output | 1 | One-cycle access acknowledge |
| sts_ps_ovf | input | 1 | Phase-shift overflow flag |
| sts_in_stop | input | 1 | Input clock stopped flag |
| sts_syn_stop | input | 1 | Synthesized clock stopped flag |
| sts_fb_stop | input | 1 | Feedback clock stopped flag |
| mul_code | output | 5 | Stored multiply-minus-one code |
| div_code | output | 5 | Stored divide-minus-one code |

## Verification
The bench builds the block with its default parameters: a 7-bit address space, 5-bit codes and an acknowledge latency of 2. These settings are small enough to sweep every one of the 128 addresses with both a write and a read. The bench also drives all 32 values of each code and all 16 combinations of the status inputs, and checks each against a model written from the requirements. A request issued one cycle into a busy window tests the drop rule.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // bit0 = phase-shift overflow ... bit3 = feedback stopped
  typedef struct packed {
    logic fb_stop;
    logic syn_stop;
    logic in_stop;
    logic ps_ovf;
  } clk_status_t;

  localparam int STATUS_W = $bits(clk_status_t);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MUL    = 2'd1,
    SEL_DIV    = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_t;

endpackage

// File: rtl/clkcfg_access_ctrl.sv
module clkcfg_access_ctrl #(
  parameter int ACK_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic accept,
  output logic busy,
  output logic rdy
);
  localparam int CNT_W = $clog2(ACK_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_LAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign busy   = (cnt != '0);
  assign accept = en & ~busy;
  assign rdy    = (cnt == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (accept) cnt <= CNT_LOAD;
    else if (busy)   cnt <= cnt - CNT_ONE;
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);                                         // R8
  AST_ACCEPT_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !rdy));                            // R10

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
  parameter int ADDR_W = 7,
  parameter int CODE_W = 5,
  parameter logic [ADDR_W-1:0] MUL_ADDR = 7'h50,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 7'h52,
  parameter logic [CODE_W-1:0] MUL_RST  = 5'd1,
  parameter logic [CODE_W-1:0] DIV_RST  = 5'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wcode,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CODE_W-1:0] mul_code,
  output logic [CODE_W-1:0] div_code
);
  logic wr_mul, wr_div;

  assign wr_mul = accept & we & (addr == MUL_ADDR) & (wcode != '0);
  assign wr_div = accept & we & (addr == DIV_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (accept) addr_q <= addr;
  end

  always_ff @(posedge clk) begin
    if (rst)         mul_code <= MUL_RST;
    else if (wr_mul) mul_code <= wcode;
  end

  always_ff @(posedge clk) begin
    if (rst)         div_code <= DIV_RST;
    else if (wr_div) div_code <= wcode;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(addr_q));                          // R1
  AST_MUL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    mul_code != '0);                                       // R6
  AST_MUL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(accept && we && addr == MUL_ADDR) |=> $stable(mul_code)); // R9
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(accept && we && addr == DIV_ADDR) |=> $stable(div_code)); // R9

endmodule

// File: rtl/clkcfg_readmux.sv
module clkcfg_readmux
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int CODE_W = 5,
  parameter logic [ADDR_W-1:0] MUL_ADDR = 7'h50,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 7'h52
) (
  input  logic [ADDR_W-1:0] addr_q,
  input  clk_status_t       status,
  input  logic [CODE_W-1:0] mul_code,
  input  logic [CODE_W-1:0] div_code,
  output logic [DATA_W-1:0] rdata
);
  rd_sel_t sel;

  always_comb begin
    if (addr_q == '0)            sel = SEL_STATUS;
    else if (addr_q == MUL_ADDR) sel = SEL_MUL;
    else if (addr_q == DIV_ADDR) sel = SEL_DIV;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rdata = {{(DATA_W-STATUS_W){1'b0}}, status};
      SEL_MUL:    rdata = {{(DATA_W-CODE_W){1'b0}}, mul_code};
      SEL_DIV:    rdata = {{(DATA_W-CODE_W){1'b0}}, div_code};
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/clkmgr_cfg_port.sv
module clkmgr_cfg_port
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int CODE_W  = 5,
  parameter int ACK_LAT = 2,
  parameter logic [ADDR_W-1:0] MUL_ADDR = 7'h50,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 7'h52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdy,
  input  logic              sts_ps_ovf,
  input  logic              sts_in_stop,
  input  logic              sts_syn_stop,
  input  logic              sts_fb_stop,
  output logic [CODE_W-1:0] mul_code,
  output logic [CODE_W-1:0] div_code
);
  logic              accept, busy;
  logic [ADDR_W-1:0] addr_q;
  clk_status_t       status;
  logic              unused_wdata_hi;

  assign status.ps_ovf   = sts_ps_ovf;
  assign status.in_stop  = sts_in_stop;
  assign status.syn_stop = sts_syn_stop;
  assign status.fb_stop  = sts_fb_stop;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CODE_W];

  clkcfg_access_ctrl #(.ACK_LAT(ACK_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .accept(accept), .busy(busy), .rdy(rdy)
  );

  clkcfg_regfile #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W),
    .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .we(we), .addr(addr),
    .wcode(wdata[CODE_W-1:0]), .addr_q(addr_q),
    .mul_code(mul_code), .div_code(div_code)
  );

  clkcfg_readmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR)
  ) u_rmux (
    .addr_q(addr_q), .status(status), .mul_code(mul_code),
    .div_code(div_code), .rdata(rdata)
  );

  AST_STATUS_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rdata == {{(DATA_W-STATUS_W){1'b0}}, status}); // R3
  AST_BUSY_NO_ACK_EARLY: assert property (@(posedge clk) disable iff (rst)
    (en && !busy) |-> !rdy);                               // R8

endmodule

// File: tb/clkmgr_cfg_port_test.sv
module clkmgr_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdy;
  logic [3:0]  sts = 4'h0;
  logic [4:0]  mul_code, div_code;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [4:0] m_mul = 5'd1, m_div = 5'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmgr_cfg_port uut (
    .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdy(rdy),
    .sts_ps_ovf(sts[0]), .sts_in_stop(sts[1]),
    .sts_syn_stop(sts[2]), .sts_fb_stop(sts[3]),
    .mul_code(mul_code), .div_code(div_code)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [6:0] a);
    if (a == 7'h00)      return {12'h000, sts};
    else if (a == 7'h50) return {11'h0, m_mul};
    else if (a == 7'h52) return {11'h0, m_div};
    else                 return 16'h0000;
  endfunction

  // One access; checks ack timing, then model and outputs
  task automatic access(input logic w, input logic [6:0] a,
                        input logic [15:0] d);
    @(negedge clk);
    en = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0;
    check("R8 rdy low at +1", {15'h0, rdy}, 16'h0);
    @(negedge clk);
    check("R8 rdy high at +2", {15'h0, rdy}, 16'h1);
    @(negedge clk);
    check("R8 rdy low at +3", {15'h0, rdy}, 16'h0);
    if (w && a == 7'h50 && d[4:0] != 5'd0) m_mul = d[4:0];
    if (w && a == 7'h52) m_div = d[4:0];
    check("R2 rdata of captured address", rdata, exp_rd(a));
    check("R5 R6 R7 R9 mul_code", {11'h0, mul_code}, {11'h0, m_mul});
    check("R7 R9 div_code", {11'h0, div_code}, {11'h0, m_div});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    sts = 4'hA;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check("R3 rdata shows status", rdata, 16'h000A);
    check("R3 mul reset", {11'h0, mul_code}, 16'h0001);
    check("R3 div reset", {11'h0, div_code}, 16'h0000);
    check("R3 rdy low", {15'h0, rdy}, 16'h0);

    // R4 all status combinations at address 0
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); sts = 4'(s);
      #1 check("R4 status bits live", rdata, {12'h0, 4'(s)});
    end

    // R1 R2 R9 sweep every address with a write then a read
    for (int a = 0; a < 128; a++) begin
      access(1'b1, 7'(a), {7'(a), 4'h0, 5'(a)});
      access(1'b0, 7'(a), 16'hFFFF);
    end

    // R5 R6 all multiply codes, upper data bits set
    for (int c = 0; c < 32; c++)
      access(1'b1, 7'h50, {11'h7FF, 5'(c)});
    check("R5 mul 31 means x32 kept", {11'h0, mul_code}, 16'h001F);
    access(1'b1, 7'h50, 16'h0000);
    check("R6 code 0 ignored", {11'h0, mul_code}, 16'h001F);

    // R7 all divide codes
    for (int c = 0; c < 32; c++)
      access(1'b1, 7'h52, {11'h5AA, 5'(c)});

    // R4 status hidden until address 0 accessed
    access(1'b0, 7'h52, 16'h0);
    sts = 4'h5;
    #1 check("R4 status hidden", rdata, {11'h0, m_div});
    access(1'b0, 7'h00, 16'h0);
    check("R4 status back after read of 0", rdata, 16'h0005);

    // R10 enable while busy is ignored
    access(1'b1, 7'h50, 16'h0003);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 7'h50; wdata = 16'h0009;
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 7'h52; wdata = 16'h0011;
    @(negedge clk);
    en = 1'b0;
    check("R10 first rdy", {15'h0, rdy}, 16'h1);
    @(negedge clk);
    check("R10 no second rdy", {15'h0, rdy}, 16'h0);
    @(negedge clk);
    check("R10 no late rdy", {15'h0, rdy}, 16'h0);
    check("R10 div untouched", {11'h0, div_code}, {11'h0, m_div});
    check("R10 address not recaptured", rdata, 16'h0009);
    check("R10 mul from accepted write", {11'h0, mul_code}, 16'h0009);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule